// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of a page table that sits in memory. A translation request carries the virtual address. At the moment the request is taken, the block also captures the frame number of the outer table and a length bound. It then reads the outer entry and, when that entry points at an inner table, reads the inner entry. It finishes with a one-cycle result that carries either the physical address or a fault with its cause.

The virtual address is cut into three fields: a 10-bit outer index in bits 31:22, a 10-bit inner index in bits 21:12 and a 12-bit byte offset in bits 11:0. Every table holds 1024 four-byte entries, so one table fills exactly one 4 KB frame. An outer entry can map a 4 MB region directly. In that case the walk ends after one read and the low 22 address bits pass through unchanged. Only one memory read is in flight at a time.

Top module: `walk2_top`

## Requirements
- R1: The outer entry is read from address {tbl_base, outer index, 2'b00}. tbl_base is the 20-bit frame number of the outer table and the outer index is virtual address bits 31:22.
- R2: A successful two-level walk makes exactly two reads. The inner entry address is {outer entry frame, inner index (VA bits 21:12), 2'b00}, and res_pa is {inner entry frame, VA bits 11:0}.
- R3: An entry holds the valid flag in bit 0, the large flag in bit 1 and the frame number in bits 31:12. The large flag is honoured only in an outer entry and has no effect in an inner entry.
- R4: A valid outer entry with the large flag set ends the walk after one read, with res_pa = {entry bits 31:22, VA bits 21:0}.
- R5: An outer index greater than or equal to tbl_len (11 bits, 0 to 1024) ends the walk with a fault of cause 1 and no memory read.
- R6: An outer entry with bit 0 clear gives a fault of cause 2 after one read. An inner entry with bit 0 clear gives a fault of cause 3 after two reads.
- R7: res_valid is a single-cycle pulse. On success res_fault is 0 and res_cause is 0. On a fault res_fault is 1 and res_cause is nonzero.
- R8: A request is taken only while req_ready is high. A request presented during a walk is ignored. tbl_base and tbl_len are captured when the request is taken, so changes during a walk have no effect on it.
- R9: mem_req lasts one cycle. No new read is issued until mem_rvalid has returned the previous one, however long the memory takes.
- R10: After reset, req_ready is 1 and both mem_req and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request will be taken |
| tbl_base | input | 20 | Frame number of the outer table |
| tbl_len | input | 11 | Number of usable outer entries |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Table entry returned by memory |
| res_valid | output | 1 | Result pulse |
| res_pa | output | 32 | Physical address (meaningful when res_fault is 0) |
| res_fault | output | 1 | Walk ended in a fault |
| res_cause | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |

## Verification
A table of addresses covers every walk ending:
- ordinary two-level hits at index extremes and offset extremes, which expose field slicing errors;
- a large-page hit, which tells the one-read path apart from the two-read path;
- an inner entry carrying a stray large flag, which shows that the flag is honoured at the outer level only;
- invalid entries at each level, which the read count and cause code separate;
- indices at and far beyond the length bound, which must fault without touching memory.

Directed runs then cover the rest:
- a reloaded base and length, which must redirect the outer read address;
- requests and base changes presented mid-walk, which must not alter the running walk;
- a slow memory, which must stretch the walk without adding reads.

// File: rtl/walk2_pkg.sv
package walk2_pkg;
   typedef enum logic [2:0] {
      W_IDLE, W_RD1, W_WT1, W_RD2, W_WT2, W_DONE, W_FLT
   } walk_st_t;

   typedef enum logic [1:0] {
      C_NONE = 2'd0,
      C_LEN  = 2'd1,
      C_L1   = 2'd2,
      C_L2   = 2'd3
   } walk_cause_t;

   localparam int PTE_V_BIT = 0;
   localparam int PTE_L_BIT = 1;
endpackage

// File: rtl/walk2_split.sv
// Cuts a captured virtual address into its index and offset fields and
// compares the outer index with the captured length bound.
module walk2_split #(
   parameter int VA_W  = 32,
   parameter int IDX_W = 10,
   parameter int OFF_W = 12,
   localparam int LOFF_W = IDX_W + OFF_W
) (
   input  logic [VA_W-1:0]   va,
   input  logic [IDX_W:0]    len,
   output logic [IDX_W-1:0]  o_idx,
   output logic [IDX_W-1:0]  i_idx,
   output logic [OFF_W-1:0]  off,
   output logic [LOFF_W-1:0] big_off,
   output logic              len_bad
);
   assign o_idx   = va[VA_W-1 -: IDX_W];
   assign i_idx   = va[OFF_W +: IDX_W];
   assign off     = va[OFF_W-1:0];
   assign big_off = va[LOFF_W-1:0];
   assign len_bad = {1'b0, o_idx} >= len;
endmodule

// File: rtl/walk2_ctl.sv
// Walk sequencer: one read at a time, fault cause kept until the result.
module walk2_ctl
   import walk2_pkg::*;
#(
   parameter bit LARGE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       len_bad,
   input  logic       mem_rvalid,
   input  logic       pte_valid,
   input  logic       pte_large,
   output logic       req_ready,
   output logic       accept,
   output logic       mem_req,
   output logic       sel_inner,
   output logic       ld_l1,
   output logic       ld_small,
   output logic       ld_big,
   output logic       res_valid,
   output logic       res_fault,
   output logic [1:0] res_cause
);
   walk_st_t    st_q, st_d;
   walk_cause_t cause_q, cause_d;

   assign req_ready = (st_q == W_IDLE);
   assign accept    = req_ready && req_valid;
   assign mem_req   = ((st_q == W_RD1) && !len_bad) || (st_q == W_RD2);
   assign sel_inner = (st_q == W_RD2);
   assign res_valid = (st_q == W_DONE) || (st_q == W_FLT);
   assign res_fault = (st_q == W_FLT);
   assign res_cause = res_fault ? cause_q : C_NONE;

   always_comb begin
      st_d     = st_q;
      cause_d  = cause_q;
      ld_l1    = 1'b0;
      ld_small = 1'b0;
      ld_big   = 1'b0;
      case (st_q)
         W_IDLE: begin
            if (accept) begin
               st_d    = W_RD1;
               cause_d = C_NONE;
            end
         end
         W_RD1: begin
            if (len_bad) begin
               st_d    = W_FLT;
               cause_d = C_LEN;
            end else begin
               st_d = W_WT1;
            end
         end
         W_WT1: begin
            if (mem_rvalid) begin
               if (!pte_valid) begin
                  st_d    = W_FLT;
                  cause_d = C_L1;
               end else if (LARGE_EN && pte_large) begin
                  st_d   = W_DONE;
                  ld_big = 1'b1;
               end else begin
                  st_d  = W_RD2;
                  ld_l1 = 1'b1;
               end
            end
         end
         W_RD2: st_d = W_WT2;
         W_WT2: begin
            if (mem_rvalid) begin
               if (!pte_valid) begin
                  st_d    = W_FLT;
                  cause_d = C_L2;
               end else begin
                  st_d     = W_DONE;
                  ld_small = 1'b1;
               end
            end
         end
         W_DONE:  st_d = W_IDLE;
         W_FLT:   st_d = W_IDLE;
         default: st_d = W_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= W_IDLE;
         cause_q <= C_NONE;
      end else begin
         st_q    <= st_d;
         cause_q <= cause_d;
      end
   end
endmodule

// File: rtl/walk2_path.sv
// Request snapshot, outer-entry frame, read address mux and result address.
module walk2_path #(
   parameter int  VA_W     = 32,
   parameter int  PA_W     = 32,
   parameter int  PTE_W    = 32,
   parameter int  IDX_W    = 10,
   parameter int  OFF_W    = 12,
   parameter bit  LARGE_EN = 1'b1,
   localparam int FRM_W  = PA_W - OFF_W,
   localparam int LOFF_W = IDX_W + OFF_W,
   localparam int LFRM_W = PA_W - LOFF_W,
   localparam int ESZ_W  = OFF_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [VA_W-1:0]   req_va,
   input  logic [FRM_W-1:0]  tbl_base,
   input  logic [IDX_W:0]    tbl_len,
   input  logic              ld_l1,
   input  logic              ld_small,
   input  logic              ld_big,
   input  logic              sel_inner,
   input  logic [PTE_W-1:0]  rdata,
   input  logic [IDX_W-1:0]  o_idx,
   input  logic [IDX_W-1:0]  i_idx,
   input  logic [OFF_W-1:0]  off,
   input  logic [LOFF_W-1:0] big_off,
   output logic [VA_W-1:0]   va_q,
   output logic [IDX_W:0]    len_q,
   output logic [PA_W-1:0]   mem_addr,
   output logic [PA_W-1:0]   res_pa
);
   logic [FRM_W-1:0] base_q;
   logic [FRM_W-1:0] l1frm_q;
   logic [PA_W-1:0]  pa_q;
   logic [PA_W-1:0]  small_pa;
   logic [PA_W-1:0]  big_pa;
   logic             unused_pte;

   assign unused_pte = ^rdata;
   assign small_pa   = {rdata[PTE_W-1 -: FRM_W], off};

   generate
      if (LARGE_EN) begin : g_big
         assign big_pa = {rdata[PTE_W-1 -: LFRM_W], big_off};
      end else begin : g_nobig
         logic unused_big;
         assign unused_big = ^big_off;
         assign big_pa     = '0;
      end
   endgenerate

   assign mem_addr = sel_inner ? {l1frm_q, i_idx, {ESZ_W{1'b0}}}
                               : {base_q,  o_idx, {ESZ_W{1'b0}}};
   assign res_pa   = pa_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q    <= '0;
         len_q   <= '0;
         base_q  <= '0;
         l1frm_q <= '0;
         pa_q    <= '0;
      end else begin
         if (accept) begin
            va_q   <= req_va;
            len_q  <= tbl_len;
            base_q <= tbl_base;
         end
         if (ld_l1)    l1frm_q <= rdata[PTE_W-1 -: FRM_W];
         if (ld_small) pa_q    <= small_pa;
         if (ld_big)   pa_q    <= big_pa;
      end
   end
endmodule

// File: rtl/walk2_top.sv
module walk2_top
   import walk2_pkg::*;
#(
   parameter int VA_W     = 32,
   parameter int PA_W     = 32,
   parameter int PTE_W    = 32,
   parameter int IDX_W    = 10,
   parameter int OFF_W    = 12,
   parameter bit LARGE_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_va,
   output logic                  req_ready,
   input  logic [PA_W-OFF_W-1:0] tbl_base,
   input  logic [IDX_W:0]        tbl_len,
   output logic                  mem_req,
   output logic [PA_W-1:0]       mem_addr,
   input  logic                  mem_rvalid,
   input  logic [PTE_W-1:0]      mem_rdata,
   output logic                  res_valid,
   output logic [PA_W-1:0]       res_pa,
   output logic                  res_fault,
   output logic [1:0]            res_cause
);
   localparam int FRM_W  = PA_W - OFF_W;
   localparam int LOFF_W = IDX_W + OFF_W;

   generate
      if (VA_W != 2 * IDX_W + OFF_W) begin : g_bad_split
         $error("walk2_top: VA_W must equal two index fields plus the offset");
      end
      if (OFF_W != IDX_W + 2) begin : g_bad_table
         $error("walk2_top: a table of 4-byte entries must fill one page");
      end
      if (PTE_W < FRM_W + 2) begin : g_bad_pte
         $error("walk2_top: entry too narrow for frame and flag bits");
      end
      if (PA_W <= LOFF_W) begin : g_bad_pa
         $error("walk2_top: physical address narrower than a large page");
      end
   endgenerate

   logic [VA_W-1:0]   va_q;
   logic [IDX_W:0]    len_q;
   logic [IDX_W-1:0]  o_idx, i_idx;
   logic [OFF_W-1:0]  off;
   logic [LOFF_W-1:0] big_off;
   logic              len_bad;
   logic              accept, sel_inner, ld_l1, ld_small, ld_big;

   walk2_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
      .va(va_q), .len(len_q), .o_idx(o_idx), .i_idx(i_idx),
      .off(off), .big_off(big_off), .len_bad(len_bad)
   );

   walk2_ctl #(.LARGE_EN(LARGE_EN)) u_ctl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .len_bad(len_bad),
      .mem_rvalid(mem_rvalid),
      .pte_valid(mem_rdata[PTE_V_BIT]), .pte_large(mem_rdata[PTE_L_BIT]),
      .req_ready(req_ready), .accept(accept), .mem_req(mem_req),
      .sel_inner(sel_inner), .ld_l1(ld_l1), .ld_small(ld_small),
      .ld_big(ld_big), .res_valid(res_valid), .res_fault(res_fault),
      .res_cause(res_cause)
   );

   walk2_path #(
      .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .IDX_W(IDX_W),
      .OFF_W(OFF_W), .LARGE_EN(LARGE_EN)
   ) u_path (
      .clk(clk), .rst_n(rst_n), .accept(accept), .req_va(req_va),
      .tbl_base(tbl_base), .tbl_len(tbl_len), .ld_l1(ld_l1),
      .ld_small(ld_small), .ld_big(ld_big), .sel_inner(sel_inner),
      .rdata(mem_rdata), .o_idx(o_idx), .i_idx(i_idx), .off(off),
      .big_off(big_off), .va_q(va_q), .len_q(len_q),
      .mem_addr(mem_addr), .res_pa(res_pa)
   );
endmodule

// File: rtl/walk2_chk.sv
module walk2_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       mem_req,
   input logic       mem_rvalid,
   input logic       res_valid,
   input logic       res_fault,
   input logic [1:0] res_cause
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (mem_req)    pend_q <= 1'b1;
      else if (mem_rvalid) pend_q <= 1'b0;
   end

   // R9: a read request lasts one cycle
   a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R9: no new read while one is outstanding
   a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !pend_q);
   // R9: no result while a read is still outstanding
   a_r9_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !pend_q);
   // R7: result is a single-cycle pulse
   a_r7_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   // R7: success carries no cause
   a_r7_ok_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_fault) |-> (res_cause == 2'd0));
   // R5 and R6: a fault always names a cause
   a_r6_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault) |-> (res_cause != 2'd0));
   // R8: a taken request leaves the idle state
   a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);
   // R10: idle walker issues no read
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req && !res_valid));
endmodule

bind walk2_top walk2_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_req(mem_req), .mem_rvalid(mem_rvalid), .res_valid(res_valid),
   .res_fault(res_fault), .res_cause(res_cause)
);

// File: tb/sim_walk2_top.sv
`timescale 1ns/1ps
module sim_walk2_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_ready;
   logic [19:0] tbl_base = '0;
   logic [10:0] tbl_len = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        res_valid;
   logic [31:0] res_pa;
   logic        res_fault;
   logic [1:0]  res_cause;

   int checks = 0;
   int fails  = 0;
   int nreads = 0;
   logic [31:0] first_addr = '0;
   int lat = 0;
   logic [31:0] mem [logic [31:0]];

   always #2.5 clk = ~clk;

   walk2_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_ready(req_ready), .tbl_base(tbl_base), .tbl_len(tbl_len),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .res_valid(res_valid), .res_pa(res_pa),
      .res_fault(res_fault), .res_cause(res_cause)
   );

   function automatic logic [31:0] look(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   // memory model with adjustable latency
   logic [31:0] pend_a = '0;
   int          cnt = 0;
   bit          pend = 0;
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         if (nreads == 0) first_addr = mem_addr;
         nreads = nreads + 1;
         pend_a = mem_addr;
         cnt    = lat;
         pend   = 1;
      end
      if (pend) begin
         if (cnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= look(pend_a);
            pend = 0;
         end else begin
            cnt = cnt - 1;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic launch(logic [31:0] va, logic [19:0] base, logic [10:0] len);
      @(negedge clk);
      nreads    = 0;
      req_valid = 1'b1;
      req_va    = va;
      tbl_base  = base;
      tbl_len   = len;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_res();
      int t = 0;
      while (!res_valid && t < 200) begin
         @(negedge clk);
         t++;
      end
   endtask

   // Vector table: base frame 0x00010, length 8
   localparam int NV = 10;
   localparam logic [31:0] V_VA [NV] = '{
      32'h00005ABC, 32'h00000000, 32'h003FFFFF, 32'h00412345, 32'h00800123,
      32'h00C02010, 32'h00007000, 32'h01C04000, 32'h02000000, 32'hFFC00000};
   localparam logic [31:0] V_PA [NV] = '{
      32'h12345ABC, 32'hABCDE000, 32'h00077FFF, 32'h00C12345, 32'h0,
      32'h00099010, 32'h0, 32'h0, 32'h0, 32'h0};
   localparam int V_CAUSE [NV] = '{0, 0, 0, 0, 2, 0, 3, 3, 1, 1};
   localparam int V_NRD   [NV] = '{2, 2, 2, 1, 1, 2, 2, 2, 0, 0};

   initial begin
      mem[32'h00010000] = 32'h00020001; // outer 0 -> inner table 0x20000
      mem[32'h00010004] = 32'h00C00003; // outer 1 -> large page, frame bits 0x003
      mem[32'h00010008] = 32'h00000000; // outer 2 invalid
      mem[32'h0001000C] = 32'h00030001; // outer 3 -> inner table 0x30000
      mem[32'h0001001C] = 32'h00040001; // outer 7 -> empty inner table
      mem[32'h00020014] = 32'h12345001;
      mem[32'h00020000] = 32'hABCDE001;
      mem[32'h00020FFC] = 32'h00077001;
      mem[32'h0002001C] = 32'h55555000; // valid bit clear
      mem[32'h00030008] = 32'h00099003; // large flag set at inner level
      mem[32'h00050000] = 32'hFFC00003; // second address space

      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 ready", {31'b0, req_ready}, 32'd1);
      chk("R10 mem_req", {31'b0, mem_req}, 32'd0);
      chk("R10 res_valid", {31'b0, res_valid}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         launch(V_VA[i], 20'h00010, 11'd8);
         chk("R8 busy after accept", {31'b0, req_ready}, 32'd0);
         wait_res();
         chk("R7 res_valid", {31'b0, res_valid}, 32'd1);
         if (V_CAUSE[i] == 0) begin
            chk(V_NRD[i] == 1 ? "R4 large pa" : "R2 pa", res_pa, V_PA[i]);
            chk("R7 no fault", {31'b0, res_fault}, 32'd0);
         end else begin
            chk(V_CAUSE[i] == 1 ? "R5 fault" : "R6 fault",
                {31'b0, res_fault}, 32'd1);
         end
         chk(V_CAUSE[i] == 1 ? "R5 cause" : "R6 cause",
             {30'b0, res_cause}, V_CAUSE[i]);
         chk(V_NRD[i] == 0 ? "R5 no read" : "R2 R4 R6 read count",
             nreads, V_NRD[i]);
         if (V_NRD[i] > 0)
            chk("R1 outer addr", first_addr,
                32'h00010000 + {20'b0, V_VA[i][31:22], 2'b00});
         if (i == 5) chk("R3 inner large flag ignored", res_pa, 32'h00099010);
         @(negedge clk);
         chk("R7 single pulse", {31'b0, res_valid}, 32'd0);
      end

      // R8: requests and base changes during a walk are ignored
      launch(32'h00005ABC, 20'h00010, 11'd8);
      req_valid = 1'b1;
      req_va    = 32'h00412345;
      tbl_base  = 20'h00050;
      tbl_len   = 11'd0;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_res();
      chk("R8 walk unaffected", res_pa, 32'h12345ABC);
      chk("R8 outer addr from snapshot", first_addr, 32'h00010000);
      nreads = 0;
      begin
         int extra = 0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (res_valid) extra++;
         end
         chk("R8 no second result", extra, 0);
      end
      chk("R8 no stray reads", nreads, 0);
      chk("R8 ready again", {31'b0, req_ready}, 32'd1);

      // R1 R4: reloaded base selects another outer table
      launch(32'h0000ABCD, 20'h00050, 11'd1);
      wait_res();
      chk("R1 new outer addr", first_addr, 32'h00050000);
      chk("R4 new large pa", res_pa, 32'hFFC0ABCD);
      chk("R4 one read", nreads, 1);

      // R5: length bound boundaries
      launch(32'h00400000, 20'h00050, 11'd1);
      wait_res();
      chk("R5 index equal to length", {30'b0, res_cause}, 32'd1);
      launch(32'h00000000, 20'h00050, 11'd0);
      wait_res();
      chk("R5 zero length", {30'b0, res_cause}, 32'd1);
      chk("R5 zero length no read", nreads, 0);
      launch(32'h00000000, 20'h00010, 11'd1024);
      wait_res();
      chk("R5 full length passes", res_pa, 32'hABCDE000);

      // R9: slow memory stretches the walk without extra reads
      lat = 4;
      launch(32'h00C02010, 20'h00010, 11'd8);
      wait_res();
      chk("R9 slow pa", res_pa, 32'h00099010);
      chk("R9 slow read count", nreads, 2);
      lat = 0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule